// File: doc/BRIEF.md
# Knock Front-End Configuration Word Decoder

This block is the programming port of a knock-signal front end. A host writes 8-bit configuration words over a write-only serial link. The link has an active-low select, a serial clock and a data line. The block turns each accepted word into a held setting for the analog chain it serves: gain, filter centre frequency, integrator time constant, sensor channel, serial-output mode and test-multiplexer routing.

Each word starts with an address prefix of two or three bits. The value that follows fills the rest of the byte. A word takes effect only when both of these hold:

- the frame carried exactly eight bits;
- the system is in hold mode at the moment the select line is released.

The serial pins and the hold input are asynchronous. They are brought into the system clock through two-flop synchronizers, and all edge detection happens on the system clock.

Top module: `knock_cfg_decoder`

## Requirements
- R1: While rst_ni is low, every output reads zero: gain_o, freq_o, tconst_o, chan_o, so_mode_o and test_sel_o.
- R2: A word with top bits 00 loads gain_o with bits [5:0]. Bits arrive most significant first, one on each sck_i falling edge while cs_ni is low.
- R3: A word with top bits 01 loads freq_o with bits [5:0].
- R4: A word with top bits 100 loads tconst_o with bits [4:0].
- R5: A word with top bits 101 loads chan_o from bit 0 and so_mode_o from bits [2:1]. Bits [4:3] are unused.
- R6: A word with top bits 110 loads test_sel_o with bits [4:0].
- R7: A word with top bits 111 changes no output.
- R8: A frame of fewer than 8 bits changes no output.
- R9: A frame of more than 8 bits changes no output.
- R10: A word is applied only if hold_i is high when cs_ni rises. A word framed with hold_i low changes no output.
- R11: An accepted word changes only the setting its prefix selects. All other outputs keep their values.
- R12: Toggling sck_i while cs_ni is high does not disturb the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock; data is taken on the falling edge |
| cs_ni | input | 1 | Active-low frame select |
| mosi_i | input | 1 | Serial data, most significant bit first |
| hold_i | input | 1 | High = hold mode; words are accepted |
| gain_o | output | 6 | Gain code |
| freq_o | output | 6 | Bandpass centre-frequency code |
| tconst_o | output | 5 | Integrator time-constant code |
| chan_o | output | 1 | Sensor channel select |
| so_mode_o | output | 2 | Serial-output mode |
| test_sel_o | output | 5 | Test-multiplexer select |

## Verification
A sequence of full 8-bit words walks through every prefix, and all six outputs are compared after each word. This shows that each prefix reaches only its own register and that values are not bit-reversed or shifted. Words with the reserved prefix and words framed outside hold mode are mixed into the same sequence, each with a recognisable value. They tell a correct rejection apart from a stray write. Frames of five and nine bits, serial-clock activity with select high, and a mid-run reset then check the bit-count rule, frame isolation and the reset state.

// File: rtl/knock_cfg_pkg.sv
package knock_cfg_pkg;
  localparam int WORD_W = 8;
  localparam int GAIN_W = 6;
  localparam int FREQ_W = 6;
  localparam int TC_W   = 5;
  localparam int SO_W   = 2;
  localparam int TEST_W = 5;

  typedef enum logic [2:0] {
    K_GAIN, K_FREQ, K_TC, K_CHAN, K_TEST, K_NONE
  } word_kind_e;

  function automatic word_kind_e kind_of(input logic [WORD_W-1:0] w);
    word_kind_e k;
    unique casez (w[WORD_W-1 -: 3])
      3'b00?:  k = K_GAIN;
      3'b01?:  k = K_FREQ;
      3'b100:  k = K_TC;
      3'b101:  k = K_CHAN;
      3'b110:  k = K_TEST;
      default: k = K_NONE;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/knock_cfg_sync.sv
module knock_cfg_sync #(
  parameter int          WIDTH  = 1,
  parameter int          STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/knock_cfg_capture.sv
module knock_cfg_capture #(
  parameter int WORD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_s_i,
  input  logic              cs_s_i,
  input  logic              mosi_s_i,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_ok_o
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              sck_d, cs_d;
  logic              sck_fall, cs_rise, cs_fall;
  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ok_q;

  assign sck_fall = sck_d & ~sck_s_i;
  assign cs_rise  = ~cs_d & cs_s_i;
  assign cs_fall  = cs_d & ~cs_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= sck_s_i;
      cs_d  <= cs_s_i;
    end
  end

  // count saturates one past a full word so overlong frames stay invalid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (cs_fall) begin
      cnt_q   <= '0;
    end else if (!cs_s_i && sck_fall) begin
      shift_q <= {shift_q[WORD_W-2:0], mosi_s_i};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else         ok_q <= cs_rise && (cnt_q == CNT_W'(WORD_W));
  end

  assign word_o     = shift_q;
  assign frame_ok_o = ok_q;
endmodule

// File: rtl/knock_cfg_bank.sv
module knock_cfg_bank
  import knock_cfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              commit_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic [TC_W-1:0]   tconst_o,
  output logic              chan_o,
  output logic [SO_W-1:0]   so_mode_o,
  output logic [TEST_W-1:0] test_sel_o
);
  word_kind_e kind;
  assign kind = kind_of(word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gain_o     <= '0;
      freq_o     <= '0;
      tconst_o   <= '0;
      chan_o     <= 1'b0;
      so_mode_o  <= '0;
      test_sel_o <= '0;
    end else if (commit_i) begin
      case (kind)
        K_GAIN: gain_o     <= word_i[GAIN_W-1:0];
        K_FREQ: freq_o     <= word_i[FREQ_W-1:0];
        K_TC:   tconst_o   <= word_i[TC_W-1:0];
        K_CHAN: begin
          chan_o    <= word_i[0];
          so_mode_o <= word_i[SO_W:1];
        end
        K_TEST: test_sel_o <= word_i[TEST_W-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/knock_cfg_decoder.sv
module knock_cfg_decoder
  import knock_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  input  logic              hold_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic [TC_W-1:0]   tconst_o,
  output logic              chan_o,
  output logic [SO_W-1:0]   so_mode_o,
  output logic [TEST_W-1:0] test_sel_o
);
  logic [3:0]        pins_s;
  logic              sck_s, cs_s, mosi_s, hold_s;
  logic [WORD_W-1:0] word_q;
  logic              frame_ok;
  logic              commit;

  knock_cfg_sync #(
    .WIDTH  (4),
    .STAGES (SYNC_STAGES),
    .RST_VAL(4'b0100)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({hold_i, cs_ni, mosi_i, sck_i}),
    .q_o   (pins_s)
  );
  assign {hold_s, cs_s, mosi_s, sck_s} = pins_s;

  knock_cfg_capture #(.WORD_W(WORD_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_s_i   (sck_s),
    .cs_s_i    (cs_s),
    .mosi_s_i  (mosi_s),
    .word_o    (word_q),
    .frame_ok_o(frame_ok)
  );

  assign commit = frame_ok & hold_s;

  knock_cfg_bank u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .commit_i  (commit),
    .word_i    (word_q),
    .gain_o    (gain_o),
    .freq_o    (freq_o),
    .tconst_o  (tconst_o),
    .chan_o    (chan_o),
    .so_mode_o (so_mode_o),
    .test_sel_o(test_sel_o)
  );
endmodule

// File: rtl/knock_cfg_checker.sv
module knock_cfg_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       frame_ok,
  input logic       commit,
  input logic [7:0] word_q,
  input logic [5:0] gain_o,
  input logic [5:0] freq_o,
  input logic [4:0] tconst_o,
  input logic       chan_o,
  input logic [1:0] so_mode_o,
  input logic [4:0] test_sel_o
);
  p_gain_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(gain_o) |-> $past(commit) && $past(word_q[7:6]) == 2'b00);

  p_gain_val_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && word_q[7:6] == 2'b00 |=> gain_o == $past(word_q[5:0]));

  p_freq_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(freq_o) |-> $past(commit) && $past(word_q[7:6]) == 2'b01);

  p_tc_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(tconst_o) |-> $past(commit) && $past(word_q[7:5]) == 3'b100);

  p_chan_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({chan_o, so_mode_o}) |-> $past(commit) && $past(word_q[7:5]) == 3'b101);

  p_test_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(test_sel_o) |-> $past(commit) && $past(word_q[7:5]) == 3'b110);

  p_rsvd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit && word_q[7:5] == 3'b111 |=>
      $stable({gain_o, freq_o, tconst_o, chan_o, so_mode_o, test_sel_o}));

  p_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_ok |=> !frame_ok);
endmodule

bind knock_cfg_decoder knock_cfg_checker u_chk (.*);

// File: tb/knock_cfg_decoder_test.sv
`timescale 1ns/1ps
module knock_cfg_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold = 1'b1;
  logic [5:0] gain, freq;
  logic [4:0] tconst, test_sel;
  logic       chan;
  logic [1:0] so_mode;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  knock_cfg_decoder uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n), .mosi_i(mosi),
    .hold_i(hold), .gain_o(gain), .freq_o(freq), .tconst_o(tconst),
    .chan_o(chan), .so_mode_o(so_mode), .test_sel_o(test_sel)
  );

  // {hold, word, gain, freq, tconst, chan, so_mode, test_sel}
  localparam int NV = 10;
  localparam logic [33:0] VEC [NV] = '{
    {1'b1, 8'h2D, 6'h2D, 6'h00, 5'h00, 1'b0, 2'd0, 5'h00},
    {1'b1, 8'h73, 6'h2D, 6'h33, 5'h00, 1'b0, 2'd0, 5'h00},
    {1'b1, 8'h96, 6'h2D, 6'h33, 5'h16, 1'b0, 2'd0, 5'h00},
    {1'b1, 8'hA7, 6'h2D, 6'h33, 5'h16, 1'b1, 2'd3, 5'h00},
    {1'b1, 8'hD9, 6'h2D, 6'h33, 5'h16, 1'b1, 2'd3, 5'h19},
    {1'b1, 8'hFF, 6'h2D, 6'h33, 5'h16, 1'b1, 2'd3, 5'h19},
    {1'b0, 8'h01, 6'h2D, 6'h33, 5'h16, 1'b1, 2'd3, 5'h19},
    {1'b1, 8'h3F, 6'h3F, 6'h33, 5'h16, 1'b1, 2'd3, 5'h19},
    {1'b1, 8'hA2, 6'h3F, 6'h33, 5'h16, 1'b0, 2'd1, 5'h19},
    {1'b1, 8'h40, 6'h3F, 6'h00, 5'h16, 1'b0, 2'd1, 5'h19}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 7:    return "R2";
      1, 9:    return "R3";
      2:       return "R4";
      3, 8:    return "R5";
      4:       return "R6";
      5:       return "R7";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, logic [24:0] exp);
    chk({tag, " gain"},  32'(gain),     32'(exp[24:19]));
    chk({tag, " freq"},  32'(freq),     32'(exp[18:13]));
    chk({tag, " tc"},    32'(tconst),   32'(exp[12:8]));
    chk({tag, " chan"},  32'(chan),     32'(exp[7]));
    chk({tag, " so"},    32'(so_mode),  32'(exp[6:5]));
    chk({tag, " test"},  32'(test_sel), 32'(exp[4:0]));
  endtask

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [15:0] bits, int n, logic h);
    hold = h;
    ticks(4);
    cs_n = 1'b0;
    ticks(8);
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i];
      sck  = 1'b1;
      ticks(8);
      sck  = 1'b0;
      ticks(8);
    end
    cs_n = 1'b1;
    ticks(12);
  endtask

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    ticks(3);
    chk_all("R1", 25'h0);
    rst_n = 1'b1;
    ticks(3);
    chk_all("R1", 25'h0);

    // R11: every field is compared after every word
    for (int i = 0; i < NV; i++) begin
      send({8'h00, VEC[i][32:25]}, 8, VEC[i][33]);
      chk_all(tag_of(i), VEC[i][24:0]);
    end

    // R8: short frame
    send(16'h0000, 5, 1'b1);
    chk_all("R8", VEC[NV-1][24:0]);

    // R9: long frame
    send(16'h0003, 9, 1'b1);
    chk_all("R9", VEC[NV-1][24:0]);

    // R12: sck activity with cs high, then a clean word
    for (int i = 0; i < 3; i++) begin
      mosi = 1'b1;
      sck = 1'b1; ticks(8);
      sck = 1'b0; ticks(8);
    end
    send(16'h008A, 8, 1'b1);
    chk("R12 tc", 32'(tconst), 32'h0A);
    chk("R12 gain", 32'(gain), 32'h3F);

    // R1: reset mid-run
    rst_n = 1'b0;
    ticks(2);
    chk_all("R1", 25'h0);
    rst_n = 1'b1;
    ticks(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule